// File: doc/BRIEF.md
# Stop-Mode Wake-Up Sequencer

This block sequences a microcontroller core into and out of its lowest-power halted state. When the CPU requests a stop, the block turns every oscillator enable off. It halts the CPU and the peripherals. At the same moment it captures the warm-up length select, the flash power-down flag and the clocking-mode inputs.

The block then waits for a rising edge on an asynchronous external wake pin. The pin passes through a synchronizer first. When the edge arrives, the block turns on the oscillators that the captured clocking mode needs and pulses a clear to the timing generator's prescaler and divider. It then holds everything halted for a selectable warm-up time.

When the flash flag was captured as set, an extra fixed wait follows the warm-up. During that wait the peripherals and the timing generator run again while the CPU stays halted, so the flash supply can settle. Release ends with a one-cycle pulse as the CPU halt drops. An active-low reset aborts the sequence at any point.

Top module: `stop_wake_seq`

## Requirements
- R1: After reset the phase output reads RUN. The phase codes on `phase_o` are RUN=0, STOP=1, WARMUP=2, CPUWAIT=3. After reset both halt outputs, `tg_clear` and `resumed` are 0.
- R2: In RUN, `stop_req`=1 at a clock edge makes the phase STOP from that edge. In STOP both oscillator enables are 0 and both halt outputs are 1.
- R3: Only a rising edge of `wake_pin` seen in STOP starts release. The phase becomes WARMUP at the third clock edge after the pin rises. A pin that is already high when STOP begins does not release the block. A wake edge while in RUN has no effect.
- R4: The oscillator enables {`hf_osc_en`,`lf_osc_en`} follow the clocking mode. Dual-clock (`dual_clk`=1) with a normal target (`target_slow`=0) gives 11. Dual-clock with a slow target gives 01. Single-clock (`dual_clk`=0) gives 10. During WARMUP and CPUWAIT the mode captured at stop entry is used; in RUN the live inputs are used.
- R5: WARMUP lasts 64, 128, 256 or 512 cycles for `warm_sel` values 0, 1, 2 and 3. The select is captured at stop entry. Both halts are 1 throughout WARMUP.
- R6: When the flash flag captured at stop entry is 1, a 32-cycle CPUWAIT follows WARMUP. In CPUWAIT `cpu_halt`=1 and `periph_halt`=0.
- R7: When the captured flash flag is 0, the block goes from WARMUP straight to RUN.
- R8: `tg_clear` is 1 for exactly the first WARMUP cycle and 0 at all other times.
- R9: `resumed` is 1 for exactly the first RUN cycle after a release sequence.
- R10: `rst_n`=0 at a clock edge puts the block in RUN with both halts 0, whatever phase it was in.
- R11: During WARMUP and CPUWAIT, `stop_req` has no effect. Changes to `warm_sel`, `flash_pd`, `dual_clk` and `target_slow` have no effect on the sequence in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stop_req | input | 1 | CPU request to enter STOP |
| wake_pin | input | 1 | Asynchronous external wake input |
| dual_clk | input | 1 | 1 = dual-clock mode, 0 = single-clock |
| target_slow | input | 1 | Dual-clock target: 1 = slow, 0 = normal |
| warm_sel | input | 2 | Warm-up length select |
| flash_pd | input | 1 | Flash power-down flag |
| hf_osc_en | output | 1 | High-frequency oscillator enable |
| lf_osc_en | output | 1 | Low-frequency oscillator enable |
| cpu_halt | output | 1 | CPU halted |
| periph_halt | output | 1 | Peripherals halted |
| tg_clear | output | 1 | Timing-generator clear pulse |
| resumed | output | 1 | One-cycle pulse as the CPU halt drops |
| phase_o | output | 2 | Current phase code |

## Verification
A wrong warm-up or wait count shows up at the ports as a phase length that is off, and it is visible the moment the block leaves WARMUP or CPUWAIT. A wrong captured mode or flag shows up directly in the oscillator enables or the halt pair, in the first cycle after the wake edge is synchronized. A broken synchronizer or edge detector shows up in one of two ways: the release starts earlier or later than three edges after the pin rises, or a pin held high releases STOP on its own.

// File: rtl/swq_pkg.sv
// Package: shared phase type and oscillator-selection helper for the
// stop-mode wake-up sequencer. Assumes two clocking modes and two targets.
package swq_pkg;

    typedef enum logic [1:0] {
        PH_RUN   = 2'd0,
        PH_STOP  = 2'd1,
        PH_WARM  = 2'd2,
        PH_CWAIT = 2'd3
    } swq_phase_t;

    // Returns {hf, lf} enables for a clocking mode and a target.
    function automatic logic [1:0] osc_pick(input logic dual, input logic slow);
        logic [1:0] r;
        if (!dual)     r = 2'b10;
        else if (slow) r = 2'b01;
        else           r = 2'b11;
        return r;
    endfunction

endpackage

// File: rtl/wake_edge_sync.sv
// Module: wake_edge_sync
// Brings an asynchronous pin into the clock domain through a flop chain and
// flags a rising edge for one cycle. Assumes STAGES >= 2 for metastability.
module wake_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic rise_o
);
    logic [STAGES-1:0] chain;
    logic              prev;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            // Each stage samples the one before it (stage 0 samples the pin).
            always_ff @(posedge clk) begin
                if (!rst_n)      chain[i] <= 1'b0;
                else if (i == 0) chain[i] <= pin_async;
                else             chain[i] <= chain[(i > 0) ? i-1 : 0];
            end
        end
    endgenerate

    // Holds the last synchronized value so an edge can be detected.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= chain[STAGES-1];
    end

    assign rise_o = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/phase_timer.sv
// Module: phase_timer
// Down-counter that times a phase. A load of N-1 gives N cycles until done.
// A load takes priority over counting; the count holds at zero.
module phase_timer #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    output logic         done
);
    logic [W-1:0] cnt;

    // Loads a new length, or counts down toward zero while running.
    always_ff @(posedge clk) begin
        if (!rst_n)                   cnt <= '0;
        else if (load)                cnt <= load_val;
        else if (run && cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/osc_gate.sv
// Module: osc_gate
// Drives the oscillator enables from the phase. Everything is off in STOP.
// The wake phases use the captured mode; RUN uses the live mode inputs.
module osc_gate
    import swq_pkg::*;
(
    input  swq_phase_t phase,
    input  logic       dual_live,
    input  logic       slow_live,
    input  logic       dual_cap,
    input  logic       slow_cap,
    output logic       hf_en,
    output logic       lf_en
);
    // Chooses the enable pair for the current phase.
    always_comb begin
        unique case (phase)
            PH_RUN:  {hf_en, lf_en} = osc_pick(dual_live, slow_live);
            PH_STOP: {hf_en, lf_en} = 2'b00;
            default: {hf_en, lf_en} = osc_pick(dual_cap, slow_cap);
        endcase
    end
endmodule

// File: rtl/stop_wake_seq.sv
// Module: stop_wake_seq (top)
// Sequences STOP entry and release: oscillator gating, warm-up, the optional
// CPU-only wait, the timing-generator clear and the resume pulse.
// Assumes stop_req is synchronous to clk and wake_pin is asynchronous.
module stop_wake_seq
    import swq_pkg::*;
#(
    parameter int WARM0  = 64,
    parameter int WARM1  = 128,
    parameter int WARM2  = 256,
    parameter int WARM3  = 512,
    parameter int CWAIT  = 32,
    parameter int SYNC_N = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stop_req,
    input  logic       wake_pin,
    input  logic       dual_clk,
    input  logic       target_slow,
    input  logic [1:0] warm_sel,
    input  logic       flash_pd,
    output logic       hf_osc_en,
    output logic       lf_osc_en,
    output logic       cpu_halt,
    output logic       periph_halt,
    output logic       tg_clear,
    output logic       resumed,
    output logic [1:0] phase_o
);
    localparam int MAX_A = (WARM0 > WARM1) ? WARM0 : WARM1;
    localparam int MAX_B = (WARM2 > WARM3) ? WARM2 : WARM3;
    localparam int MAX_W = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_L = (MAX_W > CWAIT) ? MAX_W : CWAIT;
    localparam int TW    = $clog2(MAX_L + 1);

    swq_phase_t    phase, phase_nx;
    logic [1:0]    sel_q;
    logic          flash_q, dual_q, slow_q;
    logic          wake_rise, tmr_done, tmr_load, tmr_run;
    logic [TW-1:0] tmr_val, warm_len;

    wake_edge_sync #(.STAGES(SYNC_N)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_async(wake_pin), .rise_o(wake_rise)
    );

    // Maps the captured select to its warm-up length minus one.
    always_comb begin
        unique case (sel_q)
            2'd0:    warm_len = TW'(WARM0 - 1);
            2'd1:    warm_len = TW'(WARM1 - 1);
            2'd2:    warm_len = TW'(WARM2 - 1);
            default: warm_len = TW'(WARM3 - 1);
        endcase
    end

    // Next-phase decision.
    always_comb begin
        phase_nx = phase;
        unique case (phase)
            PH_RUN:   if (stop_req)  phase_nx = PH_STOP;
            PH_STOP:  if (wake_rise) phase_nx = PH_WARM;
            PH_WARM:  if (tmr_done)  phase_nx = flash_q ? PH_CWAIT : PH_RUN;
            PH_CWAIT: if (tmr_done)  phase_nx = PH_RUN;
            default:                 phase_nx = PH_RUN;
        endcase
    end

    // Timer control: load at the start of each timed phase, count inside it.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = warm_len;
        if (phase == PH_STOP && wake_rise) begin
            tmr_load = 1'b1;
        end else if (phase == PH_WARM && tmr_done && flash_q) begin
            tmr_load = 1'b1;
            tmr_val  = TW'(CWAIT - 1);
        end
        tmr_run = (phase == PH_WARM) || (phase == PH_CWAIT);
    end

    phase_timer #(.W(TW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
        .run(tmr_run), .done(tmr_done)
    );

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_RUN;
        else        phase <= phase_nx;
    end

    // Captures the configuration at STOP entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q   <= 2'd0;
            flash_q <= 1'b0;
            dual_q  <= 1'b0;
            slow_q  <= 1'b0;
        end else if (phase == PH_RUN && stop_req) begin
            sel_q   <= warm_sel;
            flash_q <= flash_pd;
            dual_q  <= dual_clk;
            slow_q  <= target_slow;
        end
    end

    // Registers the clear pulse (first warm-up cycle) and the resume pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tg_clear <= 1'b0;
            resumed  <= 1'b0;
        end else begin
            tg_clear <= (phase == PH_STOP) && wake_rise;
            resumed  <= (phase != PH_RUN) && (phase_nx == PH_RUN);
        end
    end

    osc_gate u_osc (
        .phase(phase), .dual_live(dual_clk), .slow_live(target_slow),
        .dual_cap(dual_q), .slow_cap(slow_q),
        .hf_en(hf_osc_en), .lf_en(lf_osc_en)
    );

    assign cpu_halt    = (phase != PH_RUN);
    assign periph_halt = (phase == PH_STOP) || (phase == PH_WARM);
    assign phase_o     = phase;
endmodule

// File: rtl/swq_checker.sv
// Module: swq_checker
// Temporal checks on the sequencer, attached to every instance by bind.
module swq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] phase_o,
    input logic       hf_osc_en,
    input logic       lf_osc_en,
    input logic       cpu_halt,
    input logic       periph_halt,
    input logic       tg_clear,
    input logic       resumed,
    input logic       flash_q
);
    assert_stop_osc_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 2'd1) |-> (!hf_osc_en && !lf_osc_en && cpu_halt && periph_halt));

    assert_periph_implies_cpu_R6: assert property (@(posedge clk) disable iff (!rst_n)
        periph_halt |-> cpu_halt);

    assert_cwait_periph_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 2'd3) |-> (cpu_halt && !periph_halt));

    assert_direct_resume_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(phase_o) == 2'd2 && phase_o == 2'd0) |-> !flash_q);

    assert_clear_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tg_clear |=> !tg_clear);

    assert_clear_first_warm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tg_clear |-> (phase_o == 2'd2 && $past(phase_o) == 2'd1));

    assert_resumed_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        resumed |-> (phase_o == 2'd0 && $past(phase_o) != 2'd0));

    assert_reset_run_R10: assert property (@(posedge clk)
        !rst_n |=> (phase_o == 2'd0));
endmodule

bind stop_wake_seq swq_checker u_chk (
    .clk(clk), .rst_n(rst_n), .phase_o(phase_o),
    .hf_osc_en(hf_osc_en), .lf_osc_en(lf_osc_en),
    .cpu_halt(cpu_halt), .periph_halt(periph_halt),
    .tg_clear(tg_clear), .resumed(resumed), .flash_q(flash_q)
);

// File: tb/tb_stop_wake_seq.sv
`timescale 1ns/1ps
module tb_stop_wake_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stop_req = 1'b0, wake_pin = 1'b0, dual_clk = 1'b1, target_slow = 1'b0;
    logic [1:0] warm_sel = 2'd0;
    logic       flash_pd = 1'b0;
    logic       hf_osc_en, lf_osc_en, cpu_halt, periph_halt, tg_clear, resumed;
    logic [1:0] phase_o;
    int checks = 0, failures = 0;

    always #2.5 clk = ~clk;

    stop_wake_seq dut (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .wake_pin(wake_pin),
        .dual_clk(dual_clk), .target_slow(target_slow), .warm_sel(warm_sel),
        .flash_pd(flash_pd), .hf_osc_en(hf_osc_en), .lf_osc_en(lf_osc_en),
        .cpu_halt(cpu_halt), .periph_halt(periph_halt), .tg_clear(tg_clear),
        .resumed(resumed), .phase_o(phase_o)
    );

    function automatic int exp_warm(input int s);
        return 64 << s;
    endfunction

    function automatic logic [1:0] exp_osc(input logic d, input logic s);
        return !d ? 2'b10 : (s ? 2'b01 : 2'b11);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic enter_stop();
        @(negedge clk); stop_req = 1'b1;
        @(negedge clk); stop_req = 1'b0;
        chk(phase_o == 2'd1, "R2 phase after stop_req", phase_o, 1);
        chk({hf_osc_en, lf_osc_en} == 2'b00, "R2 osc off in STOP", {hf_osc_en, lf_osc_en}, 0);
        chk(cpu_halt && periph_halt, "R2 halts in STOP", {cpu_halt, periph_halt}, 3);
    endtask

    // Full stop/release cycle; perturb changes the live inputs mid-sequence.
    task automatic run_seq(input int sel, input bit fl, input bit du, input bit sl, input bit perturb);
        int warm_n = 0, cw_n = 0, guard = 0;
        bit first = 1'b1, warm_first_ok = 1'b1;
        logic [1:0] eo;
        warm_sel = 2'(sel); flash_pd = fl; dual_clk = du; target_slow = sl; wake_pin = 1'b0;
        eo = exp_osc(du, sl);
        enter_stop();
        repeat (3) @(negedge clk);
        chk(phase_o == 2'd1, "R3 no release without edge", phase_o, 1);
        wake_pin = 1'b1;
        repeat (2) @(negedge clk);
        chk(phase_o == 2'd1, "R3 still STOP two edges after rise", phase_o, 1);
        @(negedge clk);
        chk(phase_o == 2'd2, "R3 WARMUP at third edge", phase_o, 2);
        while (phase_o != 2'd0 && guard < 3000) begin
            if (phase_o == 2'd2) begin
                warm_n++;
                if (cw_n != 0) warm_first_ok = 1'b0;
                chk({hf_osc_en, lf_osc_en} == eo, "R4 osc in WARMUP", {hf_osc_en, lf_osc_en}, eo);
                chk(cpu_halt && periph_halt, "R5 halts in WARMUP", {cpu_halt, periph_halt}, 3);
                chk(tg_clear == first, "R8 tg_clear timing", tg_clear, first);
            end else begin
                cw_n++;
                chk({hf_osc_en, lf_osc_en} == eo, "R4 osc in CPUWAIT", {hf_osc_en, lf_osc_en}, eo);
                chk(cpu_halt && !periph_halt, "R6 halts in CPUWAIT", {cpu_halt, periph_halt}, 2);
                chk(!tg_clear, "R8 tg_clear low in CPUWAIT", tg_clear, 0);
            end
            if (first && perturb) begin
                warm_sel = ~warm_sel; flash_pd = ~fl; dual_clk = ~du; stop_req = 1'b1;
            end else begin
                stop_req = 1'b0;
            end
            first = 1'b0; guard++;
            @(negedge clk);
        end
        stop_req = 1'b0;
        chk(warm_first_ok, "R6 order WARMUP before CPUWAIT", warm_first_ok, 1);
        chk(warm_n == exp_warm(sel), "R5 warm-up length", warm_n, exp_warm(sel));
        if (fl) chk(cw_n == 32, "R6 CPUWAIT length", cw_n, 32);
        else    chk(cw_n == 0, "R7 no CPUWAIT", cw_n, 0);
        chk(resumed, "R9 resumed on first RUN cycle", resumed, 1);
        chk(!cpu_halt && !periph_halt, "R9 halts released", {cpu_halt, periph_halt}, 0);
        chk({hf_osc_en, lf_osc_en} == exp_osc(dual_clk, target_slow), "R4 osc in RUN live",
            {hf_osc_en, lf_osc_en}, exp_osc(dual_clk, target_slow));
        @(negedge clk);
        chk(!resumed, "R9 resumed one cycle only", resumed, 0);
        chk(phase_o == 2'd0, "R11 stop_req ignored mid-sequence", phase_o, 0);
        wake_pin = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        failures++; checks++;
        $display("FAIL watchdog R1..R11 actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd1234);
        repeat (3) @(negedge clk);
        chk(phase_o == 2'd0, "R10 phase during reset", phase_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(phase_o == 2'd0, "R1 phase after reset", phase_o, 0);
        chk(!cpu_halt && !periph_halt && !tg_clear && !resumed, "R1 outputs idle",
            {cpu_halt, periph_halt, tg_clear, resumed}, 0);
        chk({hf_osc_en, lf_osc_en} == 2'b11, "R4 osc in RUN dual normal", {hf_osc_en, lf_osc_en}, 3);

        // A wake edge in RUN is ignored.
        wake_pin = 1'b1; repeat (5) @(negedge clk);
        chk(phase_o == 2'd0, "R3 wake edge in RUN ignored", phase_o, 0);

        // A pin that is already high when STOP begins does not release.
        enter_stop();
        repeat (10) @(negedge clk);
        chk(phase_o == 2'd1, "R3 held-high level does not release", phase_o, 1);
        wake_pin = 1'b0; repeat (4) @(negedge clk);
        wake_pin = 1'b1; repeat (3) @(negedge clk);
        chk(phase_o == 2'd2, "R3 release after fresh edge", phase_o, 2);
        // Reset during WARMUP aborts.
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
        chk(phase_o == 2'd0 && !cpu_halt, "R10 reset aborts WARMUP", phase_o, 0);
        wake_pin = 1'b0; repeat (3) @(negedge clk);

        // Reset during STOP aborts.
        enter_stop();
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
        chk(phase_o == 2'd0 && !periph_halt, "R10 reset aborts STOP", phase_o, 0);

        // Directed corners: every select, each mode, each flag value.
        run_seq(0, 1'b0, 1'b1, 1'b0, 1'b0);
        run_seq(3, 1'b1, 1'b1, 1'b1, 1'b0);
        run_seq(1, 1'b1, 1'b0, 1'b0, 1'b1);
        run_seq(2, 1'b0, 1'b1, 1'b1, 1'b1);

        // Random mix.
        for (int i = 0; i < 16; i++) begin
            run_seq(int'($urandom_range(0, 3)), 1'($urandom), 1'($urandom),
                    1'($urandom), 1'($urandom));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule